// File: doc/BRIEF.md
# Single-Cycle Word-Wide CRC Engine

This block advances a CRC register by one whole input word on each clock. The generator polynomial, the CRC width, the data word width and the shift direction are all compile-time parameters. The core is a purely combinational network. It is built by chaining one copy of the one-bit linear feedback step per data bit, so that the next CRC is a function of the current CRC and one data word only.

A thin registered shell sits around the network. It holds the running CRC, and a synchronous reset loads it with a seed constant. On every cycle where the valid strobe is high, it takes the network's result. The shell performs no bit reflection of input or output, applies no final inversion and does no frame-level checking. A system that needs those adds them around this block.

The polynomial parameter leaves out the implied highest-order term. Bit j of the parameter says whether the feedback bit is folded into next-state bit j. The direction parameter chooses between two modes. In the left-shifting mode the most significant CRC bit drives the feedback, and the data word is taken from its top bit down. In the right-shifting mode the least significant CRC bit drives the feedback, and the data word is taken from bit 0 up.

Top module: `crc_word_engine`

## Requirements
- R1: While `rst` is high at a rising clock edge, `crc_q` becomes the SEED parameter, whatever `in_valid` and `in_data` carry.
- R2: On a clock edge with `rst` low and `in_valid` low, `crc_q` keeps its value.
- R3: With the direction parameter set to left shifting, a valid word updates `crc_q` to the result of one-bit steps applied from data bit DATA_W-1 down to bit 0. Each step works as follows. The feedback bit is the old CRC bit CRC_W-1 XOR the data bit. New bit j is old bit j-1, with a zero entering bit 0, XOR (POLY bit j AND feedback).
- R4: With the direction parameter set to right shifting, data bits are taken from bit 0 up to bit DATA_W-1. Each step works as follows. The feedback bit is the old CRC bit 0 XOR the data bit. New bit j is old bit j+1, with a zero entering bit CRC_W-1, XOR (POLY bit j AND feedback). As an example, a 16-bit CRC with POLY 0xA001 and seed 0, fed the ASCII bytes "123456789", ends at 0xBB3D.
- R5: POLY excludes the implied top term. An 8-bit left-shifting CRC with POLY 0x07 and seed 0 goes to 0x97 after the single byte 0x31. An all-zero word on an all-zero CRC leaves it zero.
- R6: When DATA_W exceeds CRC_W, each step takes its feedback from the state left by the previous step, and the result still matches R3 or R4.
- R7: A stream of valid words processed one per clock, back to back or with idle cycles between them, gives the same CRC as the bit-serial process applied to the concatenated stream.
- R8: With CRC_W = 1 and POLY = 1, the register holds the XOR of the seed with every data bit fed since reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset; loads SEED |
| in_valid | input | 1 | Fold `in_data` into the CRC on this edge |
| in_data | input | DATA_W | Data word |
| crc_q | output | CRC_W | Registered running CRC |

## Verification
The bench builds five copies of the block side by side:
- An 8-bit left-shifting CRC over bytes.
- A 16-bit right-shifting CRC over bytes.
- A 5-bit left-shifting CRC over 16-bit words with a non-zero seed.
- A 4-bit right-shifting CRC over 12-bit words.
- A 1-bit parity degenerate.

Together these reach both feedback directions and both data-bit orders. They also cover data words wider than the register in each direction, non-zero seeds, and the single-bit width where the shift path is empty. The two published check values, 0x97 and 0xBB3D, pin down the exact bit ordering. The random streams, with idle gaps and resets that arrive while valid is high, exercise hold and seeding.

// File: rtl/crcpar_pkg.sv
package crcpar_pkg;

    // Which end of the register feeds back, and which data bit goes first.
    typedef enum logic {
        SHIFT_LEFT  = 1'b0,  // feedback from top bit, data taken high index first
        SHIFT_RIGHT = 1'b1   // feedback from bit 0, data taken low index first
    } crc_dir_e;

    // Per-stage view of one single-bit update.
    typedef struct packed {
        logic din;
        logic fb;
    } step_ctl_t;

    // Feedback bit of one serial step.
    function automatic logic feedback(input logic end_bit, input logic din);
        return end_bit ^ din;
    endfunction

    // Contribution of one polynomial tap.
    function automatic logic tap(input logic poly_bit, input logic fb);
        return poly_bit & fb;
    endfunction

    // Data bit index consumed by unrolled stage k.
    function automatic int data_index(input crc_dir_e dir, input int dw, input int k);
        return (dir == SHIFT_LEFT) ? (dw - 1 - k) : k;
    endfunction

endpackage

// File: rtl/crcpar_step.sv
module crcpar_step
    import crcpar_pkg::*;
#(
    parameter int                 CRC_W = 8,
    parameter logic [CRC_W-1:0]   POLY  = 'h07,
    parameter crc_dir_e           DIR   = SHIFT_LEFT
) (
    input  logic [CRC_W-1:0] st_in,
    input  logic             din,
    output logic [CRC_W-1:0] st_out
);

    step_ctl_t ctl;
    logic [CRC_W-1:0] shifted;

    always_comb begin
        ctl.din = din;
        if (DIR == SHIFT_LEFT) ctl.fb = feedback(st_in[CRC_W-1], din);
        else                   ctl.fb = feedback(st_in[0], din);
    end

    for (genvar j = 0; j < CRC_W; j++) begin : g_bit
        if (DIR == SHIFT_LEFT) begin : g_left
            if (j == 0) begin : g_edge
                assign shifted[j] = 1'b0;
            end else begin : g_mid
                assign shifted[j] = st_in[j-1];
            end
        end else begin : g_right
            if (j == CRC_W - 1) begin : g_edge
                assign shifted[j] = 1'b0;
            end else begin : g_mid
                assign shifted[j] = st_in[j+1];
            end
        end
        assign st_out[j] = shifted[j] ^ tap(POLY[j], ctl.fb);
    end

endmodule

// File: rtl/crcpar_unroll.sv
module crcpar_unroll
    import crcpar_pkg::*;
#(
    parameter int                 CRC_W  = 8,
    parameter int                 DATA_W = 8,
    parameter logic [CRC_W-1:0]   POLY   = 'h07,
    parameter crc_dir_e           DIR    = SHIFT_LEFT
) (
    input  logic [CRC_W-1:0]  crc_in,
    input  logic [DATA_W-1:0] data_in,
    output logic [CRC_W-1:0]  crc_out
);

    localparam int STAGES = DATA_W;

    // stage[k] is the state before the k-th serial step
    logic [CRC_W-1:0] stage [STAGES+1];

    assign stage[0] = crc_in;

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        localparam int BIT_IDX = data_index(DIR, DATA_W, k);
        crcpar_step #(
            .CRC_W (CRC_W),
            .POLY  (POLY),
            .DIR   (DIR)
        ) u_step (
            .st_in  (stage[k]),
            .din    (data_in[BIT_IDX]),
            .st_out (stage[k+1])
        );
    end

    assign crc_out = stage[STAGES];

endmodule

// File: rtl/crcpar_reg.sv
module crcpar_reg #(
    parameter int               CRC_W = 8,
    parameter logic [CRC_W-1:0] SEED  = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CRC_W-1:0] d,
    output logic [CRC_W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst)       q <= SEED;
        else if (load) q <= d;
    end

endmodule

// File: rtl/crc_word_engine.sv
module crc_word_engine
    import crcpar_pkg::*;
#(
    parameter int               CRC_W  = 8,
    parameter int               DATA_W = 8,
    parameter logic [CRC_W-1:0] POLY   = 'h07,
    parameter logic [CRC_W-1:0] SEED   = '0,
    parameter crc_dir_e         DIR    = SHIFT_LEFT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic [CRC_W-1:0]  crc_q
);

    logic [CRC_W-1:0] crc_nxt;

    crcpar_unroll #(
        .CRC_W  (CRC_W),
        .DATA_W (DATA_W),
        .POLY   (POLY),
        .DIR    (DIR)
    ) u_net (
        .crc_in  (crc_q),
        .data_in (in_data),
        .crc_out (crc_nxt)
    );

    crcpar_reg #(
        .CRC_W (CRC_W),
        .SEED  (SEED)
    ) u_state (
        .clk  (clk),
        .rst  (rst),
        .load (in_valid),
        .d    (crc_nxt),
        .q    (crc_q)
    );

endmodule

// File: rtl/crcpar_chk.sv
module crcpar_chk #(
    parameter int               CRC_W  = 8,
    parameter int               DATA_W = 8,
    parameter logic [CRC_W-1:0] SEED   = '0
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [DATA_W-1:0] in_data,
    input logic [CRC_W-1:0]  crc_q,
    input logic [CRC_W-1:0]  crc_nxt
);

    // R1
    reset_seed_chk: assert property (@(posedge clk) rst |=> crc_q == SEED);

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(crc_q));

    // R7
    word_load_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> crc_q == $past(crc_nxt));

    // R5
    zero_fixpoint_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && crc_q == '0 && in_data == '0) |=> crc_q == '0);

endmodule

bind crc_word_engine crcpar_chk #(
    .CRC_W  (CRC_W),
    .DATA_W (DATA_W),
    .SEED   (SEED)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_data  (in_data),
    .crc_q    (crc_q),
    .crc_nxt  (crc_nxt)
);

// File: tb/test_crc_word_engine.sv
module test_crc_word_engine;
    import crcpar_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic vld = 1'b0;
    logic [7:0]  da = '0, db = '0, dd = '0;
    logic [15:0] dc = '0;
    logic [11:0] de = '0;
    logic [7:0]  qa;
    logic [15:0] qb;
    logic [4:0]  qc;
    logic [0:0]  qd;
    logic [3:0]  qe;

    int n_cmp = 0;
    int n_bad = 0;

    logic [63:0] ma, mb, mc, md, me;

    always #5 clk = ~clk;

    // A: 8-bit left, byte data (R3, R5)
    crc_word_engine #(.CRC_W(8), .DATA_W(8), .POLY(8'h07), .SEED(8'h00), .DIR(SHIFT_LEFT))
        i_crc_word_engine (.clk(clk), .rst(rst), .in_valid(vld), .in_data(da), .crc_q(qa));
    // B: 16-bit right, byte data (R4)
    crc_word_engine #(.CRC_W(16), .DATA_W(8), .POLY(16'hA001), .SEED(16'h0000), .DIR(SHIFT_RIGHT))
        i_b (.clk(clk), .rst(rst), .in_valid(vld), .in_data(db), .crc_q(qb));
    // C: 5-bit left, 16-bit data, non-zero seed (R6)
    crc_word_engine #(.CRC_W(5), .DATA_W(16), .POLY(5'h05), .SEED(5'h1F), .DIR(SHIFT_LEFT))
        i_c (.clk(clk), .rst(rst), .in_valid(vld), .in_data(dc), .crc_q(qc));
    // D: 1-bit parity (R8)
    crc_word_engine #(.CRC_W(1), .DATA_W(8), .POLY(1'b1), .SEED(1'b0), .DIR(SHIFT_LEFT))
        i_d (.clk(clk), .rst(rst), .in_valid(vld), .in_data(dd), .crc_q(qd));
    // E: 4-bit right, 12-bit data (R6)
    crc_word_engine #(.CRC_W(4), .DATA_W(12), .POLY(4'hC), .SEED(4'hA), .DIR(SHIFT_RIGHT))
        i_e (.clk(clk), .rst(rst), .in_valid(vld), .in_data(de), .crc_q(qe));

    // Bit-serial reference model
    function automatic logic [63:0] ref_word(input logic [63:0] crc, input logic [63:0] data,
                                             input int cw, input int dw,
                                             input logic [63:0] poly, input bit right);
        logic [63:0] mask;
        logic [63:0] c;
        mask = (cw >= 64) ? '1 : ((64'd1 << cw) - 64'd1);
        c = crc & mask;
        for (int i = 0; i < dw; i++) begin
            int idx;
            logic fb;
            idx = right ? i : (dw - 1 - i);
            if (right) begin
                fb = c[0] ^ data[idx];
                c = c >> 1;
            end else begin
                fb = c[cw-1] ^ data[idx];
                c = (c << 1) & mask;
            end
            if (fb) c = c ^ poly;
            c = c & mask;
        end
        return c;
    endfunction

    function automatic void check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endfunction

    task automatic check_all();
        check("R3 left 8-bit",        {56'd0, qa}, ma);
        check("R4 right 16-bit",      {48'd0, qb}, mb);
        check("R6 left wide data",    {59'd0, qc}, mc);
        check("R8 parity",            {63'd0, qd}, md);
        check("R6 right wide data",   {60'd0, qe}, me);
    endtask

    // Drive one cycle, advance the model with what was driven, compare after the edge.
    task automatic cycle(input bit r, input bit v, input logic [7:0] a, input logic [7:0] b,
                         input logic [15:0] c, input logic [7:0] d, input logic [11:0] e);
        rst = r; vld = v; da = a; db = b; dc = c; dd = d; de = e;
        @(posedge clk);
        #1;
        if (r) begin
            ma = 64'h00; mb = 64'h0000; mc = 64'h1F; md = 64'h0; me = 64'hA;
        end else if (v) begin
            ma = ref_word(ma, {56'd0, a}, 8, 8, 64'h07, 1'b0);
            mb = ref_word(mb, {56'd0, b}, 16, 8, 64'hA001, 1'b1);
            mc = ref_word(mc, {48'd0, c}, 5, 16, 64'h05, 1'b0);
            md = ref_word(md, {56'd0, d}, 1, 8, 64'h1, 1'b0);
            me = ref_word(me, {52'd0, e}, 4, 12, 64'hC, 1'b1);
        end
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] msg [9];
        logic [63:0] par;
        void'($urandom(32'd7345));
        msg = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};

        // R1: reset with valid high still seeds
        cycle(1, 1, 8'hFF, 8'hFF, 16'hFFFF, 8'hFF, 12'hFFF);
        cycle(1, 0, 8'h00, 8'h00, 16'h0000, 8'h00, 12'h000);
        check("R1 seed A", {56'd0, qa}, 64'h00);
        check("R1 seed C", {59'd0, qc}, 64'h1F);
        check("R1 seed E", {60'd0, qe}, 64'hA);

        // R5: single known byte
        cycle(0, 1, 8'h31, 8'h31, 16'h3132, 8'h31, 12'h031);
        check("R5 known 0x31", {56'd0, qa}, 64'h97);
        check_all();

        // R2: idle cycles with changing data leave everything unchanged
        for (int i = 0; i < 3; i++) begin
            cycle(0, 0, 8'($urandom), 8'($urandom), 16'($urandom), 8'($urandom), 12'($urandom));
            check("R2 hold A", {56'd0, qa}, 64'h97);
            check_all();
        end

        // R4/R8: nine-byte ASCII stream after reset
        cycle(1, 0, 8'h00, 8'h00, 16'h0000, 8'h00, 12'h000);
        par = 64'd0;
        for (int i = 0; i < 9; i++) begin
            cycle(0, 1, msg[i], msg[i], {msg[i], msg[i]}, msg[i], {4'h0, msg[i]});
            par = par ^ 64'($countones(msg[i]) & 1);
        end
        check("R4 check value", {48'd0, qb}, 64'hBB3D);
        check("R8 parity of stream", {63'd0, qd}, par);
        check_all();

        // R5: zero word on zero CRC stays zero
        cycle(1, 0, 8'h00, 8'h00, 16'h0000, 8'h00, 12'h000);
        cycle(0, 1, 8'h00, 8'h00, 16'h0000, 8'h00, 12'h000);
        check("R5 zero fixpoint", {56'd0, qa}, 64'h00);
        check("R5 zero fixpoint B", {48'd0, qb}, 64'h0000);

        // R6: all-ones wide word and single-bit words at both ends
        cycle(0, 1, 8'h80, 8'h01, 16'h8000, 8'h80, 12'h001);
        check_all();
        cycle(0, 1, 8'h01, 8'h80, 16'h0001, 8'h01, 12'h800);
        check_all();
        cycle(0, 1, 8'hFF, 8'hFF, 16'hFFFF, 8'hFF, 12'hFFF);
        check_all();

        // R7: random stream with idle gaps and occasional reset
        for (int i = 0; i < 400; i++) begin
            bit r, v;
            r = ($urandom % 50) == 0;
            v = ($urandom % 4) != 0;
            cycle(r, v, 8'($urandom), 8'($urandom), 16'($urandom), 8'($urandom), 12'($urandom));
            check_all();
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule